// File: doc/BRIEF.md
# Addressed Three-Wire Control Interface

This block is a serial slave that a controller reaches over three input lines (chip-enable, shift clock, data-in) and one open-drain data-out line. The controller clocks an 8-bit address while chip-enable is low and then raises chip-enable. That address chooses one of two 24-bit control-word writes or a status read. The lines are asynchronous to the chip, so the block samples them with a synchroniser on the system clock. It acts on rising edges of the shift clock as seen after that synchroniser.

A write shifts 24 data bits, least significant first, into a holding register. The target control word takes the new value only when chip-enable falls, and only if exactly 24 bits arrived. A read first freezes a snapshot of the two I/O pin states, a sticky unlock flag and a 20-bit IF count, then shifts the snapshot out one bit per clock. While no transfer is active, the data-out line serves as a status pin. A 3-bit select field in control word A chooses what it shows. The output `sb_dout_low` is the open-drain pull-down: 1 drives the line low and 0 releases it.

Top module: `sbus_ctrl_if`

## Requirements
- R1: After reset, both control words are zero, the sticky unlock flag is clear, and `sb_dout_low` is 0 (line released).
- R2: Address 0x82 followed by 24 data bits loads control word A when chip-enable falls. The first data bit lands in bit 0.
- R3: Address 0x92 followed by 24 data bits loads control word B when chip-enable falls. Control word A is left unchanged.
- R4: A write that ends with any bit count other than 24 leaves both control words unchanged.
- R5: An address other than 0x82, 0x92 or 0xA2 leaves both control words unchanged. A read (0xA2) also leaves both control words unchanged.
- R6: A read emits 24 bits, with the first bit valid once chip-enable is high and each later bit after a clock rise. The order is IO2 pin, IO1 pin, unlock bit, IF count bit 19 down to bit 0, then 0. The line is released for a 1 and pulled low for a 0.
- R7: The pin states, unlock bit and count in a read are those present when chip-enable rose. Later changes do not appear in that read.
- R8: Any cycle with `unlock_det` high sets the sticky flag. The flag is cleared only when a recognised address is accepted. A read reports the unlock bit as 0 while the flag is set and as 1 otherwise.
- R9: While chip-enable is high for anything other than a read, `sb_dout_low` is 0, whatever the select field holds.
- R10: While chip-enable is low, select field word A bits [2:0] drives the line as follows. Code 001 pulls it low while the unlock flag is set. Code 010 pulls it low while `ifc_done` is high. Code 101 copies the IO1 pin (low when the pin is low). Code 110 copies the IO2 pin. Codes 000, 011, 100 and 111 release the line.
- R11: The address is formed from the last 8 bits clocked while chip-enable was low. The bits are sent in the order B0..B3 then A0..A3, where the B bits form the upper nibble and the A bits form the lower nibble. A nibble-swapped code such as 0x28 is therefore unrecognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sb_ce | input | 1 | Serial chip-enable (asynchronous) |
| sb_clk | input | 1 | Serial shift clock (asynchronous) |
| sb_din | input | 1 | Serial data in (asynchronous) |
| sb_dout_low | output | 1 | Open-drain data-out: 1 pulls the line low |
| io_pin | input | 2 | Sampled states of the two I/O pins (bit 0 = IO1) |
| ifc_count | input | 20 | Current IF counter value |
| ifc_done | input | 1 | IF measurement complete |
| unlock_det | input | 1 | Unlock detector pulse |
| word_a | output | 24 | Control word A |
| word_b | output | 24 | Control word B |

## Verification
Two situations are hardest to reach from the ports. The first is a sticky unlock flag that is still set across the next transfer's snapshot. The second is the same flag cleared by that transfer. To reach both, the stimulus pulses `unlock_det` for a single cycle between transfers, then reads twice: the first read must report unlocked and the second must report locked. Between the two reads, the status pin (select 001) is checked for release. The snapshot rule is covered by changing pins and count after chip-enable has risen but before any bits are clocked out. Rejected writes are covered by short, long and unrecognised frames, including a nibble-swapped address.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_WR_A,
        MD_WR_B,
        MD_RD,
        MD_SKIP
    } sbus_mode_e;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_WR_A = 8'h82;
    localparam logic [ADDR_W-1:0] ADDR_WR_B = 8'h92;
    localparam logic [ADDR_W-1:0] ADDR_RD   = 8'hA2;

    localparam int unsigned SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_UNLOCK = 3'b001;
    localparam logic [SEL_W-1:0] SEL_DONE   = 3'b010;
    localparam logic [SEL_W-1:0] SEL_IO1    = 3'b101;
    localparam logic [SEL_W-1:0] SEL_IO2    = 3'b110;

    // Shift register holds first-received bit in bit 0; first four bits form
    // the upper nibble of the code, the next four the lower nibble.
    function automatic logic [ADDR_W-1:0] addr_from_shift(input logic [ADDR_W-1:0] sh);
        return {sh[3:0], sh[7:4]};
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    localparam int unsigned DEPTH = STAGES + 1;

    logic [WIDTH-1:0] pipe_d [DEPTH];
    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign lvl[b]  = pipe_q[STAGES-1][b];
        assign rise[b] = pipe_q[STAGES-1][b] & ~pipe_q[STAGES][b];
        assign fall[b] = ~pipe_q[STAGES-1][b] & pipe_q[STAGES][b];
    end

endmodule

// File: rtl/sbus_frame.sv
module sbus_frame
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned IFC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl,
    input  logic              ce_rise,
    input  logic              ce_fall,
    input  logic              cl_rise,
    input  logic              di,
    input  logic [1:0]        io_pin,
    input  logic [IFC_W-1:0]  ifc_count,
    input  logic              unlock_det,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b,
    output logic              rd_active,
    output logic              rd_bit,
    output logic              ul_flag
);

    localparam int unsigned BITS_W  = $clog2(DATA_W + 1) + 1;
    localparam int unsigned SNAP_W  = IFC_W + 3;
    localparam logic [BITS_W-1:0] FULL_CNT = BITS_W'(DATA_W);

    typedef struct packed {
        sbus_mode_e        mode;
        logic [ADDR_W-1:0] addr_sh;
        logic [DATA_W-1:0] data_sh;
        logic [BITS_W-1:0] bits;
        logic [DATA_W-1:0] out_sh;
        logic              ul;
        logic [DATA_W-1:0] word_a;
        logic [DATA_W-1:0] word_b;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [DATA_W-1:0] rd_load;

    always_comb begin
        rd_load = '0;
        rd_load[DATA_W-1 -: SNAP_W] = {io_pin[1], io_pin[0], ~fr_q.ul, ifc_count};

        fr_d = fr_q;
        if (unlock_det) begin
            fr_d.ul = 1'b1;
        end

        if (ce_rise) begin
            fr_d.bits    = '0;
            fr_d.data_sh = '0;
            case (addr_from_shift(fr_q.addr_sh))
                ADDR_WR_A: fr_d.mode = MD_WR_A;
                ADDR_WR_B: fr_d.mode = MD_WR_B;
                ADDR_RD: begin
                    fr_d.mode   = MD_RD;
                    fr_d.out_sh = rd_load;
                end
                default:   fr_d.mode = MD_SKIP;
            endcase
            if (fr_d.mode != MD_SKIP) begin
                fr_d.ul = unlock_det;
            end
        end else if (ce_fall) begin
            if (fr_q.mode == MD_WR_A && fr_q.bits == FULL_CNT) begin
                fr_d.word_a = fr_q.data_sh;
            end
            if (fr_q.mode == MD_WR_B && fr_q.bits == FULL_CNT) begin
                fr_d.word_b = fr_q.data_sh;
            end
            fr_d.mode = MD_IDLE;
        end else if (cl_rise) begin
            if (!ce_lvl) begin
                fr_d.addr_sh = {di, fr_q.addr_sh[ADDR_W-1:1]};
            end else if (fr_q.mode == MD_WR_A || fr_q.mode == MD_WR_B) begin
                fr_d.data_sh = {di, fr_q.data_sh[DATA_W-1:1]};
                if (fr_q.bits != '1) begin
                    fr_d.bits = fr_q.bits + 1'b1;
                end
            end else if (fr_q.mode == MD_RD) begin
                fr_d.out_sh = {fr_q.out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.mode    <= MD_IDLE;
            fr_q.addr_sh <= '0;
            fr_q.data_sh <= '0;
            fr_q.bits    <= '0;
            fr_q.out_sh  <= '0;
            fr_q.ul      <= 1'b0;
            fr_q.word_a  <= '0;
            fr_q.word_b  <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign word_a    = fr_q.word_a;
    assign word_b    = fr_q.word_b;
    assign rd_active = (fr_q.mode == MD_RD);
    assign rd_bit    = fr_q.out_sh[DATA_W-1];
    assign ul_flag   = fr_q.ul;

    AST_SHORT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_fall && fr_q.bits != FULL_CNT) |=> ($stable(word_a) && $stable(word_b))); // R4
    AST_SKIP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.mode == MD_SKIP || fr_q.mode == MD_RD) |=> ($stable(word_a) && $stable(word_b))); // R5
    AST_UL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_det |=> ul_flag); // R8
    AST_UL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ul_flag && !ce_rise) |=> ul_flag); // R8

endmodule

// File: rtl/sbus_dout_sel.sv
module sbus_dout_sel
    import sbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ce_lvl,
    input  logic             rd_active,
    input  logic             rd_bit,
    input  logic             ul_flag,
    input  logic             ifc_done,
    input  logic [1:0]       io_pin,
    output logic             dout_low
);

    logic dout_d, dout_q;

    always_comb begin
        if (ce_lvl) begin
            dout_d = rd_active ? ~rd_bit : 1'b0;
        end else begin
            case (sel)
                SEL_UNLOCK: dout_d = ul_flag;
                SEL_DONE:   dout_d = ifc_done;
                SEL_IO1:    dout_d = ~io_pin[0];
                SEL_IO2:    dout_d = ~io_pin[1];
                default:    dout_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout_low = dout_q;

endmodule

// File: rtl/sbus_ctrl_if.sv
module sbus_ctrl_if
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned IFC_W       = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_ce,
    input  logic              sb_clk,
    input  logic              sb_din,
    output logic              sb_dout_low,
    input  logic [1:0]        io_pin,
    input  logic [IFC_W-1:0]  ifc_count,
    input  logic              ifc_done,
    input  logic              unlock_det,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b
);

    localparam int unsigned LINES = 3;

    logic [LINES-1:0] ln_lvl, ln_rise, ln_fall;
    logic rd_active, rd_bit, ul_flag;
    logic [SEL_W-1:0] sel;

    sbus_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sb_din, sb_clk, sb_ce}),
        .lvl      (ln_lvl),
        .rise     (ln_rise),
        .fall     (ln_fall)
    );

    sbus_frame #(.DATA_W(DATA_W), .IFC_W(IFC_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl     (ln_lvl[0]),
        .ce_rise    (ln_rise[0]),
        .ce_fall    (ln_fall[0]),
        .cl_rise    (ln_rise[1]),
        .di         (ln_lvl[2]),
        .io_pin     (io_pin),
        .ifc_count  (ifc_count),
        .unlock_det (unlock_det),
        .word_a     (word_a),
        .word_b     (word_b),
        .rd_active  (rd_active),
        .rd_bit     (rd_bit),
        .ul_flag    (ul_flag)
    );

    assign sel = word_a[SEL_W-1:0];

    sbus_dout_sel u_dout (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .ce_lvl    (ln_lvl[0]),
        .rd_active (rd_active),
        .rd_bit    (rd_bit),
        .ul_flag   (ul_flag),
        .ifc_done  (ifc_done),
        .io_pin    (io_pin),
        .dout_low  (sb_dout_low)
    );

    AST_WRITE_DOUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_lvl[0] && $past(ln_lvl[0]) && !rd_active) |-> !sb_dout_low); // R9
    AST_IDLE_OPEN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ln_lvl[0] && (sel == 3'b000 || sel == 3'b011 || sel == 3'b100 || sel == 3'b111))
        |=> !sb_dout_low); // R10

endmodule

// File: tb/sbus_ctrl_if_bench.sv
module sbus_ctrl_if_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sb_ce = 1'b0;
    logic        sb_clk = 1'b0;
    logic        sb_din = 1'b0;
    logic        sb_dout_low;
    logic [1:0]  io_pin = 2'b00;
    logic [19:0] ifc_count = '0;
    logic        ifc_done = 1'b0;
    logic        unlock_det = 1'b0;
    logic [23:0] word_a, word_b;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sbus_ctrl_if u_sbus_ctrl_if (
        .clk         (clk),
        .rst_n       (rst_n),
        .sb_ce       (sb_ce),
        .sb_clk      (sb_clk),
        .sb_din      (sb_din),
        .sb_dout_low (sb_dout_low),
        .io_pin      (io_pin),
        .ifc_count   (ifc_count),
        .ifc_done    (ifc_done),
        .unlock_det  (unlock_det),
        .word_a      (word_a),
        .word_b      (word_b)
    );

    // {address, bit count, data}
    localparam logic [37:0] VEC [8] = '{
        {8'h82, 6'd24, 24'hA5C3F0},
        {8'h92, 6'd24, 24'h123456},
        {8'h82, 6'd23, 24'hFFFFFF},
        {8'h92, 6'd25, 24'h0F0F0F},
        {8'h83, 6'd24, 24'h777777},
        {8'hA2, 6'd24, 24'h3C3C3C},
        {8'h92, 6'd24, 24'hFEDCBA},
        {8'h82, 6'd24, 24'h000000}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cl(input logic bit_v);
        sb_din = bit_v;
        wait_clk(3);
        sb_clk = 1'b1;
        wait_clk(6);
        sb_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic begin_xfer(input logic [7:0] addr);
        for (int i = 0; i < 8; i++) begin
            pulse_cl(addr[(i < 4) ? i + 4 : i - 4]);
        end
        sb_ce = 1'b1;
        wait_clk(8);
    endtask

    task automatic end_xfer();
        sb_ce = 1'b0;
        wait_clk(10);
    endtask

    task automatic send_bits(input int n, input logic [23:0] data);
        for (int i = 0; i < n; i++) begin
            pulse_cl((i < 24) ? data[i] : 1'b0);
        end
    endtask

    task automatic write_word(input logic [7:0] addr, input int n, input logic [23:0] data);
        begin_xfer(addr);
        send_bits(n, data);
        end_xfer();
    endtask

    task automatic read_stream(output logic [23:0] v, input bit change_mid);
        begin_xfer(8'hA2);
        if (change_mid) begin
            io_pin    = ~io_pin;
            ifc_count = ~ifc_count;
            wait_clk(6);
        end
        v[23] = ~sb_dout_low;
        for (int k = 1; k < 24; k++) begin
            sb_clk = 1'b1;
            wait_clk(6);
            v[23-k] = ~sb_dout_low;
            sb_clk = 1'b0;
            wait_clk(6);
        end
        end_xfer();
    endtask

    task automatic pulse_unlock();
        unlock_det = 1'b1;
        wait_clk(1);
        unlock_det = 1'b0;
        wait_clk(3);
    endtask

    function automatic string vec_tag(input logic [7:0] a, input int n);
        if (n != 24 && (a == 8'h82 || a == 8'h92)) return "R4";
        if (a == 8'h82) return "R2";
        if (a == 8'h92) return "R3";
        return "R5";
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [23:0] exp_a, exp_b, strm, exp_s;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        check("R1 word_a", 32'(word_a), 32'h0);
        check("R1 word_b", 32'(word_b), 32'h0);
        check("R1 dout",   32'(sb_dout_low), 32'h0);

        // R2 R3 R4 R5: vector table
        exp_a = '0;
        exp_b = '0;
        foreach (VEC[i]) begin
            logic [7:0]  va;
            int          vn;
            logic [23:0] vd;
            va = VEC[i][37:30];
            vn = int'(VEC[i][29:24]);
            vd = VEC[i][23:0];
            write_word(va, vn, vd);
            if (va == 8'h82 && vn == 24) exp_a = vd;
            if (va == 8'h92 && vn == 24) exp_b = vd;
            check({vec_tag(va, vn), " word_a"}, 32'(word_a), 32'(exp_a));
            check({vec_tag(va, vn), " word_b"}, 32'(word_b), 32'(exp_b));
        end

        // R11: nibble-swapped address is not recognised
        write_word(8'h28, 24, 24'h555555);
        check("R11 swapped addr word_a", 32'(word_a), 32'(exp_a));

        // R6: read stream order
        io_pin    = 2'b10;
        ifc_count = 20'hA53C1;
        read_stream(strm, 1'b0);
        exp_s = {1'b1, 1'b0, 1'b1, 20'hA53C1, 1'b0};
        check("R6 stream", 32'(strm), 32'(exp_s));

        // R7: snapshot taken at chip-enable rise
        io_pin    = 2'b01;
        ifc_count = 20'h0F00F;
        read_stream(strm, 1'b1);
        exp_s = {1'b0, 1'b1, 1'b1, 20'h0F00F, 1'b0};
        check("R7 snapshot", 32'(strm), 32'(exp_s));

        // R8: sticky unlock flag, status pin with select 001
        write_word(8'h82, 24, 24'h000001);
        check("R8 flag clear idle", 32'(sb_dout_low), 32'h0);
        pulse_unlock();
        wait_clk(20);
        check("R8 flag held idle", 32'(sb_dout_low), 32'h1);
        read_stream(strm, 1'b0);
        check("R8 first read unlocked", 32'(strm[21]), 32'h0);
        check("R8 flag cleared by read", 32'(sb_dout_low), 32'h0);
        read_stream(strm, 1'b0);
        check("R8 second read locked", 32'(strm[21]), 32'h1);

        // R10: select field decode, two pin conditions per code
        for (int c = 0; c < 8; c++) begin
            write_word(8'h82, 24, 24'(c));
            pulse_unlock();
            ifc_done = 1'b1;
            io_pin   = 2'b00;
            wait_clk(6);
            check($sformatf("R10 sel=%0d asserted", c), 32'(sb_dout_low),
                  32'((c == 1 || c == 2 || c == 5 || c == 6) ? 1 : 0));
            ifc_done = 1'b0;
            io_pin   = 2'b11;
            wait_clk(6);
            check($sformatf("R10 sel=%0d deasserted", c), 32'(sb_dout_low),
                  32'((c == 1) ? 1 : 0));
        end

        // R9: line released during a write whatever the select field says
        write_word(8'h82, 24, 24'h000002);
        ifc_done = 1'b1;
        wait_clk(6);
        check("R9 idle shows done", 32'(sb_dout_low), 32'h1);
        begin_xfer(8'h92);
        send_bits(10, 24'h3FF);
        check("R9 open mid write", 32'(sb_dout_low), 32'h0);
        send_bits(14, 24'h0);
        end_xfer();
        check("R9 idle shows done again", 32'(sb_dout_low), 32'h1);
        check("R3 word_b after R9 write", 32'(word_b), 32'h0003FF);

        if (!finished) begin
            finished = 1'b1;
            report();
        end
    end

endmodule